// File: doc/BRIEF.md
# Memory-Mapped Packet Buffer Window

This block is the host-side access logic of a network controller working in memory mode. It decodes a 20-bit system address, an active-low chip select and separate active-low memory read and write strobes. When the decode matches, it maps a 4-kbyte window onto the controller's packet page. The window contains a receive status word, a receive length word, a receive frame data port and a transmit frame data port. The host may use byte or word accesses. Frame storage is held in internal byte-banked RAMs. The receive side is filled through a MAC-facing write port. The transmit side is read back through a MAC-facing read port.

The window starts out disabled, as the controller leaves reset in I/O mode. It answers only once a synchronously sampled mode-enable input is high. Its base is the upper eight address bits, taken from a sampled configuration input, so the window always begins on a 4-kbyte boundary.

Receive frame bytes near the head of the frame can be read in any order. Past that point, reads come from an internal pointer that moves strictly forward, and the address offset given by the host is ignored. Each falling strobe counts as one access, however long the strobe is held.

Top module: `pkt_window`

## Requirements
- R1: After reset, and while mode_en has not been sampled high, no access is answered: rd_valid and align_err stay 0, rdata stays 0, and writes change nothing.
- R2: An access occurs only when sys_addr[19:12] equals the sampled base_cfg, cs_n is 0 and memr_n or memw_n is 0. mode_en and base_cfg take effect one clock after they are presented.
- R3: The status word is read at offset 0x400 and the length word at offset 0x402. A byte read of offset 0x400/0x402 returns the low byte, and a byte read of 0x401/0x403 returns the high byte. Byte reads always return their byte on rdata[7:0] with rdata[15:8] = 0.
- R4: For n below 118, a read at offset 0x404+n returns frame byte n, in any order. A word read returns byte n on rdata[7:0] and byte n+1 on rdata[15:8].
- R5: A read at offset 0x404+n with n of 118 or more ignores n. It returns the bytes at a pointer that a frame-start pulse or reset sets to 118. The pointer then advances by 1 per byte read and by 2 per word read. Reads below 118 do not move it.
- R6: Writes at offset 0xA00+m store transmit byte m. A word write stores wdata[7:0] at m and wdata[15:8] at m+1. A byte write stores wdata[7:0] at m, whether m is even or odd. tx_rdata shows byte tx_raddr one clock after tx_raddr is set.
- R7: Writes to offsets 0x000–0x9FF are ignored. A read of the transmit region or of offsets below 0x400 completes with rd_valid = 1 and rdata = 0.
- R8: A word access at an odd address raises align_err for exactly one clock, gives rd_valid = 0, and neither stores data nor moves the receive pointer.
- R9: rd_valid rises on the clock edge after the strobe falls and stays high, with rdata steady, while the strobe is held. It clears on the clock edge after release. A held strobe counts as a single access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Memory-mode enable, sampled each clock |
| base_cfg | input | 8 | Window base (address bits 19:12), sampled each clock |
| sys_addr | input | 20 | System address |
| cs_n | input | 1 | Chip select, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| word_acc | input | 1 | 1 = 16-bit access, 0 = byte access |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, zero unless rd_valid |
| rd_valid | output | 1 | A decoded read is being answered |
| align_err | output | 1 | One-clock pulse for a word access at an odd address |
| rx_we | input | 1 | MAC-side receive byte write enable |
| rx_waddr | input | 11 | MAC-side receive byte offset |
| rx_wdata | input | 8 | MAC-side receive byte |
| rx_frame_start | input | 1 | New frame: sets the sequential pointer to 118 |
| rx_status | input | 16 | Receive status word from the MAC |
| rx_length | input | 16 | Receive length word from the MAC |
| tx_raddr | input | 11 | MAC-side transmit byte offset to read |
| tx_rdata | output | 8 | Transmit byte, one clock after tx_raddr |

## Verification
A wrong receive pointer cannot be seen directly at the ports. It shows up on the next sequential read as a byte taken from the wrong place in the frame, so the bench keeps its own count of the pointer. It checks the pointer after reads below 118, after misaligned words, and after held strobes. A broken bank select or byte-lane steering in the transmit store shows as swapped or missing bytes on tx_rdata one clock after the address is set. A stale edge detector shows as rd_valid lingering after release, or as a second pointer step during a held strobe.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int WIN_W = 12;
  localparam logic [WIN_W-1:0] OFF_STAT = 12'h400;
  localparam logic [WIN_W-1:0] OFF_LEN  = 12'h402;
  localparam logic [WIN_W-1:0] OFF_RXF  = 12'h404;
  localparam logic [WIN_W-1:0] OFF_TXF  = 12'hA00;

  typedef enum logic [2:0] {RG_NONE, RG_STAT, RG_LEN, RG_RXF, RG_TXF} region_t;
endpackage

// File: rtl/pw_decode.sv
module pw_decode
  import pw_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0]       sys_addr,
  input  logic [ADDR_W-WIN_W-1:0] base_q,
  input  logic                    mode_q,
  input  logic                    cs_n,
  input  logic                    memr_n,
  input  logic                    memw_n,
  input  logic                    word_acc,
  output logic                    act,
  output logic                    is_rd,
  output logic                    misalign,
  output region_t                 region,
  output logic [WIN_W-1:0]        off
);
  logic hit;

  always_comb begin
    hit      = (sys_addr[ADDR_W-1:WIN_W] == base_q);
    act      = mode_q & hit & ~cs_n & (~memr_n | ~memw_n);
    is_rd    = ~memr_n;
    off      = sys_addr[WIN_W-1:0];
    misalign = word_acc & off[0];
    if (off >= OFF_TXF)       region = RG_TXF;
    else if (off >= OFF_RXF)  region = RG_RXF;
    else if (off >= OFF_LEN)  region = RG_LEN;
    else if (off >= OFF_STAT) region = RG_STAT;
    else                      region = RG_NONE;
  end
endmodule

// File: rtl/pw_rx_store.sv
module pw_rx_store #(
  parameter int RX_AW    = 11,
  parameter int RAND_LIM = 118
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mac_we,
  input  logic [RX_AW-1:0] mac_addr,
  input  logic [7:0]       mac_data,
  input  logic             frame_start,
  input  logic             rd_go,
  input  logic             rd_word,
  input  logic [RX_AW-1:0] foff,
  output logic [7:0]       lo,
  output logic [7:0]       hi
);
  localparam int DEPTH = 2 ** (RX_AW - 1);
  localparam logic [RX_AW-1:0] LIM = RX_AW'(RAND_LIM);

  logic [7:0] ram_e [DEPTH];
  logic [7:0] ram_o [DEPTH];
  logic [RX_AW-1:0] ptr, ra;
  logic [RX_AW-2:0] idx, ie;
  logic seq, a0_q, w_q;
  logic [7:0] e_q, o_q;

  always_comb begin
    seq = (foff >= LIM);
    ra  = seq ? ptr : foff;
    idx = ra[RX_AW-1:1];
    ie  = idx + (RX_AW-1)'(ra[0]);
  end

  always_ff @(posedge clk) begin
    if (mac_we && !mac_addr[0]) ram_e[mac_addr[RX_AW-1:1]] <= mac_data;
  end

  always_ff @(posedge clk) begin
    if (mac_we && mac_addr[0]) ram_o[mac_addr[RX_AW-1:1]] <= mac_data;
  end

  always_ff @(posedge clk) begin
    if (rd_go) begin
      e_q <= ram_e[ie];
      o_q <= ram_o[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a0_q <= 1'b0;
      w_q  <= 1'b0;
      ptr  <= LIM;
    end else begin
      if (rd_go) begin
        a0_q <= ra[0];
        w_q  <= rd_word;
      end
      if (frame_start)
        ptr <= LIM;
      else if (rd_go && seq)
        ptr <= ptr + (rd_word ? RX_AW'(2) : RX_AW'(1));
    end
  end

  assign lo = a0_q ? o_q : e_q;
  assign hi = w_q ? (a0_q ? e_q : o_q) : 8'h00;

  // R5: the pointer only moves on a host read or a frame start
  a_r5_ptr_idle: assert property (@(posedge clk) disable iff (rst)
    (!rd_go && !frame_start) |=> $stable(ptr));
  // R4: random-region reads leave the pointer alone
  a_r4_random_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (rd_go && !seq && !frame_start) |=> $stable(ptr));
endmodule

// File: rtl/pw_tx_store.sv
module pw_tx_store #(
  parameter int TX_AW = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_go,
  input  logic             wr_word,
  input  logic [TX_AW-1:0] toff,
  input  logic [15:0]      wdata,
  input  logic [TX_AW-1:0] mac_raddr,
  output logic [7:0]       mac_rdata
);
  localparam int DEPTH = 2 ** (TX_AW - 1);

  logic [7:0] ram_e [DEPTH];
  logic [7:0] ram_o [DEPTH];
  logic [7:0] e_q, o_q;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (wr_go && (wr_word || !toff[0])) ram_e[toff[TX_AW-1:1]] <= wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (wr_go && (wr_word || toff[0]))
      ram_o[toff[TX_AW-1:1]] <= wr_word ? wdata[15:8] : wdata[7:0];
  end

  always_ff @(posedge clk) begin
    e_q <= ram_e[mac_raddr[TX_AW-1:1]];
    o_q <= ram_o[mac_raddr[TX_AW-1:1]];
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= mac_raddr[0];
  end

  assign mac_rdata = sel_q ? o_q : e_q;

  // R8: the decoder never lets a misaligned word reach the store
  a_r8_tx_word_even: assert property (@(posedge clk) disable iff (rst)
    (wr_go && wr_word) |-> !toff[0]);
endmodule

// File: rtl/pkt_window.sv
module pkt_window
  import pw_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int RX_AW    = 11,
  parameter int TX_AW    = 11,
  parameter int RAND_LIM = 118
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_en,
  input  logic [ADDR_W-WIN_W-1:0] base_cfg,
  input  logic [ADDR_W-1:0]       sys_addr,
  input  logic                    cs_n,
  input  logic                    memr_n,
  input  logic                    memw_n,
  input  logic                    word_acc,
  input  logic [15:0]             wdata,
  output logic [15:0]             rdata,
  output logic                    rd_valid,
  output logic                    align_err,
  input  logic                    rx_we,
  input  logic [RX_AW-1:0]        rx_waddr,
  input  logic [7:0]              rx_wdata,
  input  logic                    rx_frame_start,
  input  logic [15:0]             rx_status,
  input  logic [15:0]             rx_length,
  input  logic [TX_AW-1:0]        tx_raddr,
  output logic [7:0]              tx_rdata
);
  logic mode_q, act, act_q, is_rd, misalign, go, good;
  logic [ADDR_W-WIN_W-1:0] base_q;
  logic [WIN_W-1:0] off;
  region_t region, region_q;
  logic rd_valid_q, align_err_q, word_q, odd_q;
  logic [15:0] reg_q, word_mux;
  logic [7:0] rx_lo, rx_hi;
  logic rx_go, tx_go;

  pw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sys_addr(sys_addr), .base_q(base_q), .mode_q(mode_q), .cs_n(cs_n),
    .memr_n(memr_n), .memw_n(memw_n), .word_acc(word_acc), .act(act),
    .is_rd(is_rd), .misalign(misalign), .region(region), .off(off));

  assign go    = act & ~act_q;
  assign good  = go & ~misalign;
  assign rx_go = good & is_rd & (region == RG_RXF);
  assign tx_go = good & ~is_rd & (region == RG_TXF);

  pw_rx_store #(.RX_AW(RX_AW), .RAND_LIM(RAND_LIM)) u_rx (
    .clk(clk), .rst(rst), .mac_we(rx_we), .mac_addr(rx_waddr),
    .mac_data(rx_wdata), .frame_start(rx_frame_start), .rd_go(rx_go),
    .rd_word(word_acc), .foff(RX_AW'(off - OFF_RXF)), .lo(rx_lo), .hi(rx_hi));

  pw_tx_store #(.TX_AW(TX_AW)) u_tx (
    .clk(clk), .rst(rst), .wr_go(tx_go), .wr_word(word_acc),
    .toff(TX_AW'(off - OFF_TXF)), .wdata(wdata), .mac_raddr(tx_raddr),
    .mac_rdata(tx_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= 1'b0;
      base_q      <= '0;
      act_q       <= 1'b0;
      rd_valid_q  <= 1'b0;
      align_err_q <= 1'b0;
      region_q    <= RG_NONE;
      word_q      <= 1'b0;
      odd_q       <= 1'b0;
      reg_q       <= '0;
    end else begin
      mode_q      <= mode_en;
      base_q      <= base_cfg;
      act_q       <= act;
      rd_valid_q  <= act & is_rd & ~misalign & (go | rd_valid_q);
      align_err_q <= go & misalign;
      if (good && is_rd) begin
        region_q <= region;
        word_q   <= word_acc;
        odd_q    <= off[0];
        reg_q    <= (region == RG_STAT) ? rx_status : rx_length;
      end
    end
  end

  always_comb begin
    case (region_q)
      RG_STAT, RG_LEN:
        word_mux = word_q ? reg_q : {8'h00, (odd_q ? reg_q[15:8] : reg_q[7:0])};
      RG_RXF:  word_mux = {rx_hi, rx_lo};
      default: word_mux = 16'h0000;
    endcase
  end

  assign rdata     = rd_valid_q ? word_mux : 16'h0000;
  assign rd_valid  = rd_valid_q;
  assign align_err = align_err_q;

  // R1: a disabled window never answers
  a_r1_off_silent: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> (!rd_valid_q && !align_err_q));
  // R8: a misaligned access never produces read data
  a_r8_err_blocks_read: assert property (@(posedge clk) disable iff (rst)
    align_err_q |-> !rd_valid_q);
  // R8: error flag lasts one clock
  a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
    align_err_q |=> !align_err_q);
  // R9: valid read data follows an asserted read strobe and chip select
  a_r9_valid_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_valid_q |-> $past(!memr_n && !cs_n));
  // R7: transmit region reads as zero
  a_r7_tx_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_q && region_q == RG_TXF) |-> (rdata == 16'h0000));
endmodule

// File: tb/pkt_window_bench.sv
module pkt_window_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_en = 1'b0;
  logic [7:0] base_cfg = 8'hD0;
  logic [19:0] sys_addr = '0;
  logic cs_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1, word_acc = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rd_valid, align_err;
  logic rx_we = 1'b0;
  logic [10:0] rx_waddr = '0;
  logic [7:0] rx_wdata = '0;
  logic rx_frame_start = 1'b0;
  logic [15:0] rx_status = 16'hA5C3, rx_length = 16'h0190;
  logic [10:0] tx_raddr = '0;
  logic [7:0] tx_rdata;

  int checks = 0, failures = 0;
  bit done = 0;
  logic hold_bad;
  logic post_v;
  logic [15:0] post_d;
  int ep;

  always #2.5 clk = ~clk;

  pkt_window u_pkt_window (
    .clk(clk), .rst(rst), .mode_en(mode_en), .base_cfg(base_cfg),
    .sys_addr(sys_addr), .cs_n(cs_n), .memr_n(memr_n), .memw_n(memw_n),
    .word_acc(word_acc), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .align_err(align_err), .rx_we(rx_we), .rx_waddr(rx_waddr),
    .rx_wdata(rx_wdata), .rx_frame_start(rx_frame_start),
    .rx_status(rx_status), .rx_length(rx_length), .tx_raddr(tx_raddr),
    .tx_rdata(tx_rdata));

  function automatic logic [7:0] fb(input int n);
    return 8'((n * 7 + 3) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [19:0] a, input logic w, input logic wr,
                     input logic csel, input logic [15:0] wd, input int hold,
                     output logic [15:0] d, output logic v, output logic e);
    @(negedge clk);
    sys_addr = a; word_acc = w; wdata = wd;
    cs_n = ~csel; memr_n = wr; memw_n = ~wr;
    @(negedge clk);
    d = rdata; v = rd_valid; e = align_err;
    hold_bad = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (rd_valid !== v || rdata !== d || align_err !== 1'b0) hold_bad = 1'b1;
    end
    cs_n = 1'b1; memr_n = 1'b1; memw_n = 1'b1;
    @(negedge clk);
    post_v = rd_valid; post_d = rdata;
  endtask

  task automatic rd(input logic [19:0] a, input logic w, output logic [15:0] d,
                    output logic v, output logic e);
    acc(a, w, 1'b0, 1'b1, 16'h0, 0, d, v, e);
  endtask

  task automatic wr(input logic [19:0] a, input logic w, input logic [15:0] wd);
    logic [15:0] d; logic v, e;
    acc(a, w, 1'b1, 1'b1, wd, 0, d, v, e);
  endtask

  task automatic txb(input int a, output logic [7:0] d);
    @(negedge clk); tx_raddr = 11'(a);
    @(negedge clk); d = tx_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d; logic v, e;
    chk("R1 reset rd_valid", {15'b0, rd_valid}, 16'h0);
    chk("R1 reset align_err", {15'b0, align_err}, 16'h0);
    chk("R1 reset rdata", rdata, 16'h0);
    rd(20'hD0400, 1'b1, d, v, e);
    chk("R1 disabled read valid", {15'b0, v}, 16'h0);
    chk("R1 disabled read data", d, 16'h0);
    wr(20'hD0A00, 1'b1, 16'hBEEF);
  endtask

  task automatic t_decode;
    logic [15:0] d; logic v, e;
    acc(20'hD0400, 1'b1, 1'b0, 1'b0, 16'h0, 0, d, v, e);
    chk("R2 no chip select", {15'b0, v}, 16'h0);
    rd(20'hE0400, 1'b1, d, v, e);
    chk("R2 wrong base", {15'b0, v}, 16'h0);
    rd(20'hD0400, 1'b1, d, v, e);
    chk("R2 hit valid", {15'b0, v}, 16'h1);
    chk("R2 hit data", d, 16'hA5C3);
  endtask

  task automatic t_regs;
    logic [15:0] d; logic v, e;
    rd(20'hD0401, 1'b0, d, v, e); chk("R3 status high byte", d, 16'h00A5);
    rd(20'hD0400, 1'b0, d, v, e); chk("R3 status low byte", d, 16'h00C3);
    rd(20'hD0402, 1'b1, d, v, e); chk("R3 length word", d, 16'h0190);
    rd(20'hD0403, 1'b0, d, v, e); chk("R3 length high byte", d, 16'h0001);
  endtask

  task automatic t_rand;
    logic [15:0] d; logic v, e;
    rd(20'hD0404 + 20'd10, 1'b1, d, v, e);
    chk("R4 word at 10", d, {fb(11), fb(10)});
    rd(20'hD0404 + 20'd117, 1'b0, d, v, e);
    chk("R4 byte at 117", d, {8'h0, fb(117)});
    rd(20'hD0404 + 20'd5, 1'b0, d, v, e);
    chk("R4 byte at 5", d, {8'h0, fb(5)});
    rd(20'hD0404 + 20'd3, 1'b0, d, v, e);
    chk("R4 byte at 3 after 5", d, {8'h0, fb(3)});
  endtask

  task automatic t_seq;
    logic [15:0] d; logic v, e;
    @(negedge clk); rx_frame_start = 1'b1;
    @(negedge clk); rx_frame_start = 1'b0;
    ep = 118;
    rd(20'hD0404 + 20'd200, 1'b0, d, v, e);
    chk("R5 first seq byte", d, {8'h0, fb(ep)}); ep += 1;
    rd(20'hD0404 + 20'd300, 1'b1, d, v, e);
    chk("R5 seq word odd ptr", d, {fb(ep + 1), fb(ep)}); ep += 2;
    rd(20'hD0404 + 20'd120, 1'b0, d, v, e);
    chk("R5 seq byte", d, {8'h0, fb(ep)}); ep += 1;
    rd(20'hD0404 + 20'd400, 1'b1, d, v, e);
    chk("R5 seq word even ptr", d, {fb(ep + 1), fb(ep)}); ep += 2;
    rd(20'hD0404 + 20'd2, 1'b0, d, v, e);
    chk("R5 random read in middle", d, {8'h0, fb(2)});
    rd(20'hD0404 + 20'd118, 1'b0, d, v, e);
    chk("R5 ptr unmoved by random", d, {8'h0, fb(ep)}); ep += 1;
  endtask

  task automatic t_hold;
    logic [15:0] d; logic v, e;
    acc(20'hD0404 + 20'd150, 1'b0, 1'b0, 1'b1, 16'h0, 3, d, v, e);
    chk("R9 held read data", d, {8'h0, fb(ep)}); ep += 1;
    chk("R9 steady while held", {15'b0, hold_bad}, 16'h0);
    chk("R9 valid clears on release", {15'b0, post_v}, 16'h0);
    chk("R9 data zero on release", post_d, 16'h0);
    rd(20'hD0404 + 20'd150, 1'b0, d, v, e);
    chk("R9 single step per hold", d, {8'h0, fb(ep)}); ep += 1;
  endtask

  task automatic t_tx;
    logic [7:0] b;
    logic [7:0] exp [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    wr(20'hD0A00, 1'b1, 16'h2211);
    wr(20'hD0A02, 1'b0, 16'h0033);
    wr(20'hD0A03, 1'b0, 16'h0044);
    wr(20'hD0A04, 1'b1, 16'h6655);
    for (int i = 0; i < 6; i++) begin
      txb(i, b);
      chk("R6 tx byte order", {8'h0, b}, {8'h0, exp[i]});
    end
  endtask

  task automatic t_ignore;
    logic [15:0] d; logic v, e;
    wr(20'hD0404 + 20'd4, 1'b1, 16'hFFFF);
    rd(20'hD0404 + 20'd4, 1'b0, d, v, e);
    chk("R7 rx frame not writable", d, {8'h0, fb(4)});
    wr(20'hD0400, 1'b1, 16'h0000);
    rd(20'hD0400, 1'b1, d, v, e);
    chk("R7 status not writable", d, 16'hA5C3);
    rd(20'hD0A00, 1'b1, d, v, e);
    chk("R7 tx read valid", {15'b0, v}, 16'h1);
    chk("R7 tx read zero", d, 16'h0);
    rd(20'hD0010, 1'b1, d, v, e);
    chk("R7 low offset zero", d, 16'h0);
  endtask

  task automatic t_align;
    logic [15:0] d; logic v, e; logic [7:0] b;
    rd(20'hD0405, 1'b1, d, v, e);
    chk("R8 odd word err", {15'b0, e}, 16'h1);
    chk("R8 odd word no valid", {15'b0, v}, 16'h0);
    chk("R8 odd word no data", d, 16'h0);
    chk("R8 err one clock", {15'b0, align_err}, 16'h0);
    wr(20'hD0A01, 1'b1, 16'hEEEE);
    txb(1, b); chk("R8 tx byte1 kept", {8'h0, b}, 16'h0022);
    txb(2, b); chk("R8 tx byte2 kept", {8'h0, b}, 16'h0033);
    rd(20'hD0404 + 20'd201, 1'b1, d, v, e);
    chk("R8 seq odd word err", {15'b0, e}, 16'h1);
    rd(20'hD0404 + 20'd200, 1'b0, d, v, e);
    chk("R8 ptr unmoved by err", d, {8'h0, fb(ep)}); ep += 1;
  endtask

  initial begin
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      rx_we = 1'b1; rx_waddr = 11'(n); rx_wdata = fb(n);
    end
    @(negedge clk); rx_we = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    mode_en = 1'b1;
    @(negedge clk); @(negedge clk);
    t_decode;
    t_regs;
    t_rand;
    t_seq;
    t_hold;
    t_tx;
    t_ignore;
    t_align;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule